// File: doc/BRIEF.md
# Nibble Stream Scrambler with Escape-Pair Resynchronisation

This block whitens a stream of 4-bit nibbles before line coding. Each nibble arrives with two tags: a command tag that marks it as part of a command byte, and an escape flag. The escape flag is a separate fifth code, so an escape can never be confused with a data value. Data nibbles are XORed with four bits from a 10-bit pseudo-random generator. Command nibbles, escapes included, leave unchanged. The generator still steps for every nibble it accepts, whatever its tag.

Two escapes in a row mark a resynchronising cell start. When the second escape of a pair is accepted, the generator goes back to all ones, so the next nibble sees the key 1111b. Every escape that directly follows another escape reloads the generator. A run of three escapes followed by a timing command therefore leaves the generator freshly seeded on the third escape. It first steps on the nibble after that escape.

The block raises a one-cycle pulse when the generator has gone through all 1023 states since its last reload. An upstream framer uses this pulse to schedule the next resynchronising cell start. Nibbles enter and leave through valid/ready handshakes, with one register stage between input and output.

Top module: `nibble_scrambler`

## Requirements
- R1: While `rst` is high and in the cycle after, `out_valid` and `wrap_o` are 0 and `in_ready` is 1. The generator starts at all ones, so the first data nibble accepted after reset is XORed with 1111b.
- R2: The generator is a 10-bit register g. One step shifts it left by one bit and fills bit 0 with g[9]^g[6], which is the recurrence x^10+x^7+1 with period 1023. An accepted data nibble d leaves as d ^ g[9:6], with bit 3 paired with g[9]. The generator then takes four steps.
- R3: An accepted nibble with `in_cmd`=1 leaves with its value unchanged, and the generator still takes four steps.
- R4: An accepted escape (`in_cmd`=1 and `in_esc`=1) that directly follows another accepted escape loads the generator with 10'h3FF instead of stepping it. The next nibble accepted is keyed with 1111b.
- R5: In the accepted sequence escape, escape, escape, command '8', the second and third escapes each reload the generator. The command '8' is keyed from 10'h3FF, and only then does the generator step.
- R6: `wrap_o` pulses for one cycle, in the cycle after the 1023rd nibble accepted since the last reload or reset. When it pulses the generator is back at 10'h3FF. A reload restarts this count.
- R7: `in_ready` = !`out_valid` || `out_ready`. An output that is not taken holds `out_nib`, `out_cmd` and `out_esc` stable. An accepted nibble appears on the output one cycle after acceptance.
- R8: `out_cmd` and `out_esc` carry the tags of the nibble they belong to. An escape flag is only honoured together with the command tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input nibble present |
| in_ready | output | 1 | Block can take a nibble |
| in_nib | input | 4 | Input nibble value |
| in_cmd | input | 1 | Nibble belongs to a command byte |
| in_esc | input | 1 | Nibble is the escape code |
| out_valid | output | 1 | Output nibble present |
| out_ready | input | 1 | Downstream takes the output nibble |
| out_nib | output | 4 | Scrambled or passed-through nibble |
| out_cmd | output | 1 | Command tag of the output nibble |
| out_esc | output | 1 | Escape flag of the output nibble |
| wrap_o | output | 1 | Generator has completed a full period |

## Verification
The embedded assertions assume two things about the inputs. An escape flag always comes with the command tag. The downstream side may hold `out_ready` low for any number of cycles, and the output must then stay frozen. The stimulus only raises `in_esc` together with `in_cmd`. It draws `out_ready` at random in the mixed phase, so stalls happen often. Escape pairs are kept rare, so that one directed stretch of 1100 data nibbles can carry the generator through a complete period.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    parameter int NIB_W = 4;

    typedef struct packed {
        logic             valid;
        logic [NIB_W-1:0] nib;
        logic             cmd;
        logic             esc;
    } nsc_out_t;

endpackage

// File: rtl/nsc_prng.sv
module nsc_prng #(
    parameter int GEN_W = 10,
    parameter int TAP_B = 7,
    parameter int STEPS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             reload,
    output logic [STEPS-1:0] key,
    output logic [GEN_W-1:0] state
);
    localparam logic [GEN_W-1:0] SEED = {GEN_W{1'b1}};

    logic [GEN_W-1:0] gen_d, gen_q;
    logic [GEN_W-1:0] walk;

    always_comb begin
        walk = gen_q;
        for (int i = 0; i < STEPS; i++) begin
            walk = {walk[GEN_W-2:0], walk[GEN_W-1] ^ walk[TAP_B-1]};
        end
        gen_d = gen_q;
        if (reload) begin
            gen_d = SEED;
        end else if (advance) begin
            gen_d = walk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= SEED;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign key   = gen_q[GEN_W-1 -: STEPS];
    assign state = gen_q;

    AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (rst)
        reload |=> (gen_q == SEED)) else $error("reload did not seed");   // R4
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        gen_q != '0) else $error("generator locked at zero");             // R2

endmodule

// File: rtl/nsc_esc_track.sv
module nsc_esc_track (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic is_esc,
    output logic pair
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (accept) begin
            prev_d = is_esc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign pair = accept & is_esc & prev_q;

    AST_PAIR_AFTER_ESC: assert property (@(posedge clk) disable iff (rst)
        pair |-> ($past(accept && is_esc) || !$past(accept))) else $error("pair without escape"); // R5

endmodule

// File: rtl/nsc_period.sv
module nsc_period #(
    parameter int GEN_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic reload,
    output logic wrap
);
    localparam int PERIOD = (1 << GEN_W) - 1;
    localparam int CNT_W  = $clog2(PERIOD + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap_d, wrap_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_d = 1'b0;
        if (accept) begin
            if (reload) begin
                cnt_d = '0;
            end else if (cnt_q == CNT_W'(PERIOD - 1)) begin
                cnt_d  = '0;
                wrap_d = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= wrap_d;
        end
    end

    assign wrap = wrap_q;

    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q) else $error("wrap longer than one cycle");   // R6

endmodule

// File: rtl/nibble_scrambler.sv
module nibble_scrambler #(
    parameter int GEN_W = 10,
    parameter int TAP_B = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [3:0] in_nib,
    input  logic       in_cmd,
    input  logic       in_esc,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [3:0] out_nib,
    output logic       out_cmd,
    output logic       out_esc,
    output logic       wrap_o
);
    import nsc_pkg::*;

    nsc_out_t         o_d, o_q;
    logic             accept;
    logic             is_esc;
    logic             reload;
    logic [NIB_W-1:0] key;
    logic [GEN_W-1:0] gen_state;

    assign in_ready = !o_q.valid || out_ready;
    assign accept   = in_valid && in_ready;
    assign is_esc   = in_cmd && in_esc;

    nsc_esc_track u_esc (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .is_esc (is_esc),
        .pair   (reload)
    );

    nsc_prng #(.GEN_W(GEN_W), .TAP_B(TAP_B), .STEPS(NIB_W)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .advance (accept),
        .reload  (reload),
        .key     (key),
        .state   (gen_state)
    );

    nsc_period #(.GEN_W(GEN_W)) u_per (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .reload (reload),
        .wrap   (wrap_o)
    );

    always_comb begin
        o_d = o_q;
        if (accept) begin
            o_d.valid = 1'b1;
            o_d.nib   = in_cmd ? in_nib : (in_nib ^ key);
            o_d.cmd   = in_cmd;
            o_d.esc   = is_esc;
        end else if (out_ready) begin
            o_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_nib   = o_q.nib;
    assign out_cmd   = o_q.cmd;
    assign out_esc   = o_q.esc;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_nib) && $stable(out_cmd) && $stable(out_esc)))
        else $error("output moved while stalled");                                 // R7
    AST_CMD_PASS: assert property (@(posedge clk) disable iff (rst)
        (accept && in_cmd) |=> (out_cmd && out_nib == $past(in_nib))) else $error("command altered"); // R3
    AST_WRAP_AT_SEED: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (gen_state == {GEN_W{1'b1}})) else $error("wrap off seed");       // R6
    AST_ESC_TAGGED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_esc) |-> out_cmd) else $error("untagged escape");          // R8

endmodule

// File: tb/sim_nibble_scrambler.sv
module sim_nibble_scrambler;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ready, in_cmd, in_esc;
    logic [3:0] in_nib;
    logic       out_valid, out_ready, out_cmd, out_esc, wrap_o;
    logic [3:0] out_nib;

    always #2.5 clk = ~clk;

    nibble_scrambler u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_nib(in_nib), .in_cmd(in_cmd), .in_esc(in_esc),
        .out_valid(out_valid), .out_ready(out_ready), .out_nib(out_nib),
        .out_cmd(out_cmd), .out_esc(out_esc), .wrap_o(wrap_o)
    );

    int errors = 0;
    int checks = 0;
    int wraps_seen = 0;
    bit done = 1'b0;
    string req = "R2";

    logic [9:0] m_gen;
    logic       m_prev;
    int         m_cnt;
    bit         pend_wrap;
    logic [5:0] expq[$];
    int         out_seen;
    logic [3:0] first_nib;

    function automatic logic [9:0] step4(input logic [9:0] s);
        logic [9:0] t = s;
        for (int i = 0; i < 4; i++) t = {t[8:0], t[9] ^ t[6]};
        return t;
    endfunction

    task automatic check(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_gen = 10'h3FF; m_prev = 1'b0; m_cnt = 0; pend_wrap = 1'b0;
        expq.delete();
    endtask

    task automatic cyc(input bit v, input logic [3:0] n, input bit c, input bit e, input bit ordy);
        bit esc_now, pair;
        @(negedge clk);
        if (!rst) begin
            check("R6", wrap_o, pend_wrap);
            if (wrap_o) wraps_seen++;
        end
        in_valid = v; in_nib = n; in_cmd = c; in_esc = e; out_ready = ordy;
        #1;
        if (!rst) begin
            check("R7", in_ready, (!out_valid || out_ready));
            if (out_valid && out_ready) begin
                if (expq.size() == 0) check({req, " spurious"}, 1, 0);
                else begin
                    logic [5:0] x = expq.pop_front();
                    check(req, {out_nib, out_cmd, out_esc}, x);
                    if (out_seen == 0) first_nib = out_nib;
                    out_seen++;
                end
            end
            pend_wrap = 1'b0;
            if (in_valid && in_ready) begin
                esc_now = c && e;
                pair = esc_now && m_prev;
                expq.push_back({c ? n : (n ^ m_gen[9:6]), c, esc_now});
                if (pair) begin
                    m_gen = 10'h3FF; m_cnt = 0;
                end else begin
                    m_gen = step4(m_gen);
                    if (m_cnt == 1022) begin m_cnt = 0; pend_wrap = 1'b1; end
                    else m_cnt++;
                end
                m_prev = esc_now;
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5C3A_91E7));
        in_valid = 0; in_nib = 0; in_cmd = 0; in_esc = 0; out_ready = 1;
        rst = 1'b1;
        model_reset();
        out_seen = 0;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);
        check("R1 out_valid", out_valid, 0);
        check("R1 wrap", wrap_o, 0);
        check("R1 in_ready", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after", out_valid, 0);
        check("R1 in_ready after", in_ready, 1);

        req = "R1";
        cyc(1, 4'h0, 0, 0, 1);
        req = "R2";
        for (int i = 0; i < 20; i++) cyc(1, 4'($urandom), 0, 0, 1);
        drain();
        check("R1 first data keyed 1111", first_nib, 4'hF);

        req = "R3";
        for (int i = 0; i < 12; i++) cyc(1, 4'($urandom), 1, 0, 1);
        for (int i = 0; i < 6; i++) cyc(1, 4'($urandom), 0, 0, 1);

        req = "R4";
        cyc(1, 4'h0, 1, 1, 1); cyc(1, 4'h0, 1, 1, 1);
        cyc(1, 4'h5, 0, 0, 1);
        drain();
        check("R4 nibble after pair", out_nib, 4'hA);

        req = "R5";
        cyc(1, 4'h0, 1, 1, 1); cyc(1, 4'h0, 1, 1, 1); cyc(1, 4'h0, 1, 1, 1);
        cyc(1, 4'h8, 1, 0, 1);
        cyc(1, 4'h3, 0, 0, 1);
        drain();
        check("R5 data after X_X_X_8", out_nib, 4'h3 ^ step4(10'h3FF)[9:6]);

        req = "R6";
        cyc(1, 4'h0, 1, 1, 1); cyc(1, 4'h0, 1, 1, 1);
        for (int i = 0; i < 1100; i++) cyc(1, 4'($urandom), ($urandom % 8) == 0, 0, 1);
        drain();
        check("R6 wrap observed", wraps_seen > 0, 1);

        req = "R7";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 40;
            bit c = (r < 6);
            bit e = (r < 2);
            cyc(($urandom % 4) != 0, 4'($urandom), c, e, ($urandom % 3) != 0);
        end
        req = "R8";
        for (int i = 0; i < 2500; i++) cyc(1, 4'($urandom), ($urandom % 5) == 0, 0, 1);
        drain();
        check("R8 queue empty", expq.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule